// File: doc/BRIEF.md
# EEPROM Programming Port Controller

This block sits between a host register port and the four pins of a small serial configuration EEPROM (16-bit words, 3-wire plus data-out). It turns host writes into EEPROM activity in one of two ways.

The first way is a manual pin-drive mode for programming a blank device on the board. The host unlocks it by setting the load bit in a write to the config-B register while the protection input is low. Each later write to the data port then latches three host data bits straight onto chip select, serial clock and data-in. The second way is an automatic write-back of the three configuration bytes. With protection present, setting the load bit arms a collector that takes the next three config-B writes. The block then runs the whole EEPROM command sequence by itself: write-enable, two word writes with ready polling, and write-disable. The load bit reads back as 1 until that sequence completes.

Top module: `eeprog_port`

## Requirements
- R1: A config-B write (wr_sel = 0) with bit 6 (load bit) set, made while idle and while prot_ok is low, enters pin-drive mode. The same write with prot_ok high does not; it starts the write-back instead.
- R2: In pin-drive mode, a data-port write (wr_sel = 1) puts wr_data[3], wr_data[2] and wr_data[1] on ee_cs, ee_sk and ee_di from the next clock edge. The pins hold those values until the next data-port write. The other data bits have no effect, and the block adds no clocking of its own.
- R3: A data-port write made while the block is not in pin-drive mode leaves all three EEPROM output pins unchanged.
- R4: Pin-drive mode ends only at reset. Config-B writes of any value made in that mode change neither the mode nor the pins, and the load bit reads 1 throughout the mode.
- R5: During write-back, the three config-B writes that follow the starting write are captured in order as A, B and C. Data-port writes made in between are not counted.
- R6: After the third capture, the block sends four frames in this order, MSB first, on rising SK edges with CS high. The frames are: 1,00,11 followed by zero address bits (write-enable); 1,01, address 2^ADDR_W-2, data {B,A} with B in the high byte; 1,01, address 2^ADDR_W-1, data {8'h73,C}; and 1,00,00 followed by zero address bits (write-disable).
- R7: After each word write, CS drops and then rises with SK low. CS stays high until ee_do reads 1, and no further frame starts before that.
- R8: Read-back (cfg_rdata) shows bit 6 as 1 from the starting write until the write-disable frame and its trailing gap are complete, then as 0. The other bits show the last config-B write made while idle.
- R9: Outside pin-drive mode, SK is never high while CS is low.
- R10: When neither mode is active, ee_cs, ee_sk and ee_di are all low.
- R11: After reset, the pins are low and cfg_rdata reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 = config-B register, 1 = data port |
| wr_data | input | 8 | Host write data |
| cfg_rdata | output | 8 | Config-B read-back with the load bit replaced by busy status |
| prot_ok | input | 1 | High when the EEPROM protection code is present |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data-in |
| ee_do | input | 1 | EEPROM serial data-out / ready |

## Verification
The assertions check the following on every cycle: that pin-drive mode is only entered with protection low and never leaves it, that the pins hold steady between data-port writes in that mode, that SK is never high without CS during write-back, and that the pins are low whenever the block is idle. Only the bench's scenarios can show the rest. That covers the bit order and content of the four command frames, the capture order of A, B and C, that no frame starts before the EEPROM reports ready, and the read-back of the load bit across a full write-back. The bench shows these by decoding the serial pins with its own EEPROM model.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BANG, ST_COLLECT, ST_CMD, ST_SHIFT, ST_GAP, ST_POLL
  } ctl_state_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [7:0] CODE_BYTE = 8'h73;
  localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/eeprog_shifter.sv
module eeprog_shifter #(
  parameter int unsigned CLK_HALF = 2,
  parameter int unsigned FRAME_W  = 23,
  parameter int unsigned LEN_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  output logic               cs,
  output logic               sk,
  output logic               di,
  output logic               done
);
  localparam int unsigned DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic               active_q, active_n;
  logic               phase_q, phase_n;
  logic [DIV_W-1:0]   div_q, div_n;
  logic [LEN_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               done_q, done_n;

  always_comb begin
    active_n = active_q;
    phase_n  = phase_q;
    div_n    = div_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    done_n   = 1'b0;
    if (!active_q) begin
      if (start) begin
        active_n = 1'b1;
        phase_n  = 1'b0;
        div_n    = '0;
        cnt_n    = len;
        sh_n     = frame;
      end
    end else if (div_q == DIV_W'(CLK_HALF - 1)) begin
      div_n = '0;
      if (!phase_q) begin
        phase_n = 1'b1;
      end else begin
        phase_n = 1'b0;
        sh_n    = {sh_q[FRAME_W-2:0], 1'b0};
        if (cnt_q == LEN_W'(1)) begin
          active_n = 1'b0;
          done_n   = 1'b1;
        end else begin
          cnt_n = cnt_q - LEN_W'(1);
        end
      end
    end else begin
      div_n = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      div_q    <= '0;
      cnt_q    <= '0;
      sh_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      phase_q  <= phase_n;
      div_q    <= div_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      done_q   <= done_n;
    end
  end

  assign cs   = active_q;
  assign sk   = active_q & phase_q;
  assign di   = active_q & sh_q[FRAME_W-1];
  assign done = done_q;
endmodule

// File: rtl/eeprog_ctl.sv
module eeprog_ctl
  import eeprog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LOAD_BIT = 6,
  parameter int unsigned GAP_LEN  = 4,
  parameter int unsigned FRAME_W  = 23,
  parameter int unsigned LEN_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               prot_ok,
  input  logic               ee_do,
  input  logic               shift_done,
  output logic               shift_start,
  output logic [FRAME_W-1:0] shift_frame,
  output logic [LEN_W-1:0]   shift_len,
  output logic               poll_cs,
  output logic               bang_mode,
  output logic               busy,
  output logic [7:0]         cfg_rdata
);
  localparam int unsigned GAP_W = $clog2(GAP_LEN + 1);
  localparam logic [ADDR_W-1:0] ADDR_LO = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] ADDR_HI = {ADDR_W{1'b1}};

  ctl_state_t      state_q, state_n;
  logic [1:0]      cnt_q, cnt_n;
  logic [1:0]      step_q, step_n;
  logic            polled_q, polled_n;
  logic [GAP_W-1:0] gap_q, gap_n;
  logic [2:0][7:0] cap_q, cap_n;
  logic [7:0]      cfg_q, cfg_n;
  logic            cfgb_wr, step_is_write;

  assign cfgb_wr       = wr_en & ~wr_sel;
  assign step_is_write = step_q[0] ^ step_q[1];

  always_comb begin
    state_n     = state_q;
    cnt_n       = cnt_q;
    step_n      = step_q;
    polled_n    = polled_q;
    gap_n       = gap_q;
    cap_n       = cap_q;
    cfg_n       = cfg_q;
    shift_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cfgb_wr) begin
        cfg_n = wr_data;
        if (wr_data[LOAD_BIT]) begin
          if (prot_ok) begin
            state_n = ST_COLLECT;
            cnt_n   = 2'd0;
          end else begin
            state_n = ST_BANG;
          end
        end
      end
      ST_BANG: ;
      ST_COLLECT: if (cfgb_wr) begin
        cap_n[cnt_q] = wr_data;
        if (cnt_q == 2'd2) begin
          state_n = ST_CMD;
          step_n  = 2'd0;
        end else begin
          cnt_n = cnt_q + 2'd1;
        end
      end
      ST_CMD: begin
        shift_start = 1'b1;
        state_n     = ST_SHIFT;
      end
      ST_SHIFT: if (shift_done) begin
        state_n = ST_GAP;
        gap_n   = '0;
      end
      ST_GAP: if (gap_q == GAP_W'(GAP_LEN - 1)) begin
        if (step_is_write && !polled_q) begin
          state_n = ST_POLL;
        end else begin
          polled_n = 1'b0;
          if (step_q == 2'd3) begin
            state_n = ST_IDLE;
          end else begin
            step_n  = step_q + 2'd1;
            state_n = ST_CMD;
          end
        end
      end else begin
        gap_n = gap_q + GAP_W'(1);
      end
      ST_POLL: if (ee_do) begin
        polled_n = 1'b1;
        state_n  = ST_GAP;
        gap_n    = '0;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      step_q   <= '0;
      polled_q <= 1'b0;
      gap_q    <= '0;
      cap_q    <= '0;
      cfg_q    <= '0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      step_q   <= step_n;
      polled_q <= polled_n;
      gap_q    <= gap_n;
      cap_q    <= cap_n;
      cfg_q    <= cfg_n;
    end
  end

  always_comb begin
    unique case (step_q)
      2'd0: begin
        shift_frame = {1'b1, OP_EXT, 2'b11, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
        shift_len   = LEN_W'(3 + ADDR_W);
      end
      2'd1: begin
        shift_frame = {1'b1, OP_WRITE, ADDR_LO, cap_q[1], cap_q[0]};
        shift_len   = LEN_W'(FRAME_W);
      end
      2'd2: begin
        shift_frame = {1'b1, OP_WRITE, ADDR_HI, CODE_BYTE, cap_q[2]};
        shift_len   = LEN_W'(FRAME_W);
      end
      default: begin
        shift_frame = {1'b1, OP_EXT, 2'b00, {(ADDR_W-2){1'b0}}, {WORD_W{1'b0}}};
        shift_len   = LEN_W'(3 + ADDR_W);
      end
    endcase
  end

  assign poll_cs   = (state_q == ST_POLL);
  assign bang_mode = (state_q == ST_BANG);
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    cfg_rdata           = cfg_q;
    cfg_rdata[LOAD_BIT] = busy;
  end
endmodule

// File: rtl/eeprog_pinmux.sv
module eeprog_pinmux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bang_mode,
  input  logic       port_wr,
  input  logic [2:0] port_bits,
  input  logic       seq_cs,
  input  logic       seq_sk,
  input  logic       seq_di,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di
);
  logic [2:0] pins_q, pins_n;

  always_comb begin
    pins_n = pins_q;
    if (bang_mode && port_wr) pins_n = port_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_n;
  end

  assign ee_cs = bang_mode ? pins_q[2] : seq_cs;
  assign ee_sk = bang_mode ? pins_q[1] : seq_sk;
  assign ee_di = bang_mode ? pins_q[0] : seq_di;
endmodule

// File: rtl/eeprog_port.sv
module eeprog_port
  import eeprog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CLK_HALF = 2,
  parameter int unsigned LOAD_BIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] cfg_rdata,
  input  logic       prot_ok,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di,
  input  logic       ee_do
);
  localparam int unsigned FRAME_W = 3 + ADDR_W + WORD_W;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);
  localparam int unsigned GAP_LEN = 2 * CLK_HALF;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic               shift_start, shift_done, poll_cs;
  logic               bang_mode, busy;
  logic [FRAME_W-1:0] shift_frame;
  logic [LEN_W-1:0]   shift_len;
  logic               sh_cs, sh_sk, sh_di;

  eeprog_ctl #(
    .ADDR_W(ADDR_W), .LOAD_BIT(LOAD_BIT), .GAP_LEN(GAP_LEN),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) i_ctl (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .prot_ok(prot_ok), .ee_do(ee_do),
    .shift_done(shift_done), .shift_start(shift_start),
    .shift_frame(shift_frame), .shift_len(shift_len), .poll_cs(poll_cs),
    .bang_mode(bang_mode), .busy(busy), .cfg_rdata(cfg_rdata)
  );

  eeprog_shifter #(
    .CLK_HALF(CLK_HALF), .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) i_shift (
    .clk(clk), .rst_n(rst_int_n), .start(shift_start), .frame(shift_frame),
    .len(shift_len), .cs(sh_cs), .sk(sh_sk), .di(sh_di), .done(shift_done)
  );

  eeprog_pinmux i_pins (
    .clk(clk), .rst_n(rst_int_n), .bang_mode(bang_mode),
    .port_wr(wr_en & wr_sel), .port_bits(wr_data[3:1]),
    .seq_cs(sh_cs | poll_cs), .seq_sk(sh_sk), .seq_di(sh_di),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
  );
endmodule

// File: rtl/eeprog_port_chk.sv
module eeprog_port_chk (
  input logic clk,
  input logic rst_n,
  input logic prot_ok,
  input logic wr_en,
  input logic wr_sel,
  input logic bang_mode,
  input logic busy,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  p_bang_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bang_mode) |-> !$past(prot_ok));

  p_bang_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bang_mode && !(wr_en && wr_sel)) |=> $stable({ee_cs, ee_sk, ee_di}));

  p_bang_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bang_mode |=> bang_mode);

  p_sk_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && !bang_mode) |-> ee_cs);

  p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));
endmodule

bind eeprog_port eeprog_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .prot_ok(prot_ok), .wr_en(wr_en),
  .wr_sel(wr_sel), .bang_mode(bang_mode), .busy(busy),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/test_eeprog_port.sv
module test_eeprog_port;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC   = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       prot_ok = 1'b0;
  logic       ee_do = 1'b1;
  logic [7:0] cfg_rdata;
  logic       ee_cs, ee_sk, ee_di;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprog_port i_eeprog_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_rdata(cfg_rdata), .prot_ok(prot_ok),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // EEPROM model, sampled on the falling clock edge
  logic [31:0] rx;
  int          nb = 0, nf = 0, polls = 0, busy_cnt = 0, early = 0;
  logic        prev_cs = 1'b0, prev_sk = 1'b0, model_on = 1'b0;
  logic [31:0] fr_val [8];
  int          fr_len [8];

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (model_on) begin
      if (ee_cs && ee_sk && !prev_sk) begin
        if (nb == 0 && busy_cnt != 0) early = early + 1;
        rx = {rx[30:0], ee_di};
        nb = nb + 1;
      end
      if (!ee_cs && prev_cs) begin
        if (nb == 0) polls = polls + 1;
        else if (nf < 8) begin
          fr_val[nf] = rx;
          fr_len[nf] = nb;
          nf = nf + 1;
          if (nb == 23 && rx[22:20] == 3'b101) busy_cnt = BUSY_CYC;
        end
        nb = 0;
        rx = '0;
      end
    end
    ee_do   = (busy_cnt == 0);
    prev_cs = ee_cs;
    prev_sk = ee_sk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic prot);
    @(negedge clk);
    rst_n = 1'b0; prot_ok = prot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // {sel, data, expected {cs,sk,di}}
  localparam logic [11:0] BANG_VEC [8] = '{
    {1'b1, 8'h08, 3'b100},
    {1'b1, 8'h0C, 3'b110},
    {1'b1, 8'h08, 3'b100},
    {1'b1, 8'h0A, 3'b101},
    {1'b0, 8'h00, 3'b101},
    {1'b1, 8'h0E, 3'b111},
    {1'b1, 8'hF1, 3'b000},
    {1'b1, 8'h04, 3'b010}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset(1'b1);
    check("R11 pins", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);
    check("R11 rdata", {24'b0, cfg_rdata}, 32'h0);
    model_on = 1'b1;

    // R8 idle write stored
    host_wr(1'b0, 8'h06);
    check("R8 idle readback", {24'b0, cfg_rdata}, 32'h06);

    // R1/R5 start write-back with protection present
    host_wr(1'b0, 8'h46);
    check("R8 busy during collect", {31'b0, cfg_rdata[6]}, 32'h1);
    host_wr(1'b1, 8'h0E);
    check("R3 data port ignored", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);
    host_wr(1'b0, 8'h3C);
    host_wr(1'b0, 8'h81);
    host_wr(1'b0, 8'h5A);
    for (int i = 0; i < 5000 && cfg_rdata[6]; i++) @(negedge clk);
    check("R8 busy clears", {31'b0, cfg_rdata[6]}, 32'h0);
    check("R8 readback after", {24'b0, cfg_rdata}, 32'h06);
    check("R6 frame count", nf, 4);
    check("R6 ewen", fr_val[0], 32'h4C);
    check("R6 ewen len", fr_len[0], 7);
    check("R6 R5 word lo", fr_val[1], {9'b0, 3'b101, 4'hE, 8'h81, 8'h3C});
    check("R6 word hi", fr_val[2], {9'b0, 3'b101, 4'hF, 8'h73, 8'h5A});
    check("R6 ewds", fr_val[3], 32'h40);
    check("R6 ewds len", fr_len[3], 7);
    check("R7 polls", polls, 2);
    check("R7 no early frame", early, 0);
    check("R10 idle pins", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);
    host_wr(1'b1, 8'h0E);
    check("R1 R3 no bang with prot", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);

    // R1 pin-drive mode with protection absent
    model_on = 1'b0;
    do_reset(1'b0);
    host_wr(1'b1, 8'h0E);
    check("R3 before unlock", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);
    host_wr(1'b0, 8'h40);
    check("R4 load reads 1", {31'b0, cfg_rdata[6]}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      host_wr(BANG_VEC[i][11], BANG_VEC[i][10:3]);
      repeat (3) @(negedge clk);
      check(BANG_VEC[i][11] ? "R2 bang pins" : "R4 cfg write in bang",
            {29'b0, ee_cs, ee_sk, ee_di}, {29'b0, BANG_VEC[i][2:0]});
    end
    host_wr(1'b0, 8'h00);
    host_wr(1'b1, 8'h0A);
    check("R4 still in bang", {29'b0, ee_cs, ee_sk, ee_di}, 32'h5);

    // R4 reset leaves pin-drive mode
    do_reset(1'b0);
    check("R4 R11 pins after reset", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);
    host_wr(1'b1, 8'h0E);
    check("R4 R3 no bang after reset", {29'b0, ee_cs, ee_sk, ee_di}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule